// File: doc/BRIEF.md
# Dual-Edge Hit Time Stamper

This block puts a fine arrival time on every new burst of activity seen on one pixel column's combined hit line. That line is the OR of every discriminator output in the column, so it reaches the block with no relation to the clock. The block samples the line on both the rising and the falling edge of its fast clock. It merges the two sample streams into one sequence with half-period spacing and looks for a low-to-high change in that sequence. The result is a time code with a resolution of half a clock period. At 170 MHz that is about 2.94 ns per bin.

Each time code carries two parts. The coarse part counts full clock periods since reset. The least significant bit tells whether the falling-edge sample or the rising-edge sample saw the change first. Because the coarse part comes from the shared clock count, downstream logic can match it against hit addresses that arrive later from the slower readout. Time codes wait in a short first-in-first-out queue until the consumer pulls them. A sticky flag records that a code was lost because the queue was full. After a code is taken, the line must be seen low for a whole clock period before another rising change counts. A line that a busy pixel holds high therefore cannot trigger again.

Top module: `dets_stamper`

## Requirements
- R1: After reset, `ts_valid` and `ts_overflow` are 0. The first rising clock edge after reset is released is period 0 of the coarse count.
- R2: `ts_data[12:1]` holds the period index k of the rising clock edge that starts the half-period in which the hit line was first seen high. `ts_data[0]` is the phase bit.
- R3: A line that goes high between rising edge k and the next falling edge gives coarse k and phase bit 1.
- R4: A line that goes high between a falling edge and the next rising edge k gives coarse k and phase bit 0.
- R5: When the queue is empty, a code with coarse k first appears on `ts_valid` just after rising edge k+3. It is not present after edge k+2.
- R6: A line held high for any number of periods yields exactly one code.
- R7: A low interval that covers only one sample yields no new code. Two consecutive low samples (one full period) re-arm the block, so a rise in the very next sample produces a new code.
- R8: Codes leave in arrival order. Up to 8 are held. `ts_valid` is 1 while any are held, and `ts_data` stays stable until a cycle with `ts_ready` high removes the head.
- R9: A code that arrives while 8 are held is discarded, and the 8 held codes are kept. `ts_overflow` then rises and stays 1 until reset.
- R10: The coarse count wraps modulo 4096. A rise seen first at rising edge 4096 gives coarse 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_in | input | 1 | Asynchronous column hit line (OR of the pixel outputs) |
| ts_ready | input | 1 | Consumer takes the head code in this cycle |
| ts_valid | output | 1 | A code is available on ts_data |
| ts_data | output | 13 | Coarse period count (bits 12:1) and phase bit (bit 0) |
| ts_overflow | output | 1 | Sticky: a code was lost to a full queue |

## Verification
A wrong arming state shows at the ports within about four periods of the stimulus that exposes it. It appears either as a missing code after a clean full-period gap, or as an extra code after a single-sample dropout. The extra code sits right behind the first one in the queue. A slip between the two sample chains, or a wrong latency offset, shows as a phase bit that is off by one or a coarse value that is off by one period on the first code after reset. Queue pointer or count faults show when an overfilled queue is drained: a code is reordered, duplicated or missing, and `ts_valid` drops at the wrong entry.

// File: rtl/dets_pkg.sv
`timescale 1ns/1ps
package dets_pkg;

    // Phase bit of a time code: which sample of the period saw the rise first.
    typedef enum logic {
        HALF_RISE = 1'b0,
        HALF_FALL = 1'b1
    } half_e;

    // Fewest synchronizer flops allowed on each sample path.
    localparam int MIN_SYNC = 2;

endpackage

// File: rtl/dets_sampler.sv
`timescale 1ns/1ps
// Two synchronizer chains of equal depth, one clocked on each clock edge.
module dets_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_async,
    output logic smp_rise,
    output logic smp_fall
);
    localparam int S = (STAGES < dets_pkg::MIN_SYNC) ? dets_pkg::MIN_SYNC : STAGES;

    logic [S-1:0] rise_d, rise_q;
    logic [S-1:0] fall_d, fall_q;

    always_comb begin
        rise_d = {rise_q[S-2:0], hit_async};
        fall_d = {fall_q[S-2:0], hit_async};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rise_q <= '0;
        else        rise_q <= rise_d;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= fall_d;
    end

    assign smp_rise = rise_q[S-1];
    assign smp_fall = fall_q[S-1];

endmodule

// File: rtl/dets_edge_find.sv
`timescale 1ns/1ps
// Walks the interleaved samples, with the rising-edge sample before the
// falling-edge sample, finds 0->1 changes, and applies the one-period re-arm rule.
module dets_edge_find #(
    parameter int CNT_W = 12,
    parameter int LAT   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_rise,
    input  logic             smp_fall,
    output logic             ev_valid,
    output logic [CNT_W:0]   ev_stamp
);
    import dets_pkg::*;

    localparam logic [CNT_W-1:0] LAT_C = CNT_W'(LAT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             prev_fall;
        logic             armed;
        logic             ev;
        logic [CNT_W:0]   stamp;
    } st_t;

    st_t   s_d, s_q;
    logic  hit_rise, hit_fall, arm_mid;
    half_e phase;

    always_comb begin
        s_d     = s_q;
        s_d.cnt = s_q.cnt + 1'b1;

        // Rising-edge sample of period k comes after falling sample of k-1.
        hit_rise = s_q.armed & ~s_q.prev_fall & smp_rise;
        if (hit_rise)                          arm_mid = 1'b0;
        else if (~s_q.prev_fall & ~smp_rise)   arm_mid = 1'b1;
        else                                   arm_mid = s_q.armed;

        // Falling-edge sample of period k comes after rising sample of k.
        hit_fall = arm_mid & ~smp_rise & smp_fall;
        if (hit_fall)                          s_d.armed = 1'b0;
        else if (~smp_rise & ~smp_fall)        s_d.armed = 1'b1;
        else                                   s_d.armed = arm_mid;

        phase         = hit_fall ? HALF_FALL : HALF_RISE;
        s_d.prev_fall = smp_fall;
        s_d.ev        = hit_rise | hit_fall;
        s_d.stamp     = {s_q.cnt - LAT_C, logic'(phase)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.armed     <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign ev_valid = s_q.ev;
    assign ev_stamp = s_q.stamp;

    // R7
    fall_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_stamp[0]) |=> !ev_valid);

endmodule

// File: rtl/dets_fifo.sv
`timescale 1ns/1ps
// Small first-word-fall-through queue with a sticky loss flag.
module dets_fifo #(
    parameter int W     = 13,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_req,
    input  logic [W-1:0] wr_data,
    input  logic         rd_req,
    output logic         rd_valid,
    output logic [W-1:0] rd_data,
    output logic         ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          ovf;
    } fs_t;

    fs_t          f_d, f_q;
    logic [W-1:0] mem [DEPTH];
    logic         full, empty, do_wr, do_rd;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full  = (f_q.cnt == CW'(DEPTH));
        empty = (f_q.cnt == '0);
        do_wr = wr_req & ~full;
        do_rd = rd_req & ~empty;
        f_d   = f_q;
        if (do_wr) f_d.wp = bump(f_q.wp);
        if (do_rd) f_d.rp = bump(f_q.rp);
        case ({do_wr, do_rd})
            2'b10:   f_d.cnt = f_q.cnt + 1'b1;
            2'b01:   f_d.cnt = f_q.cnt - 1'b1;
            default: f_d.cnt = f_q.cnt;
        endcase
        if (wr_req && full) f_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[f_q.wp] <= wr_data;
    end

    assign rd_valid = ~empty;
    assign rd_data  = mem[f_q.rp];
    assign ovf      = f_q.ovf;

    // R8
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.cnt <= CW'(DEPTH));

    // R9
    loss_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !rd_valid == 1'b0 && f_q.cnt == CW'(DEPTH)) |=> ovf);

    // R9
    loss_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

endmodule

// File: rtl/dets_stamper.sv
`timescale 1ns/1ps
// Top: dual-edge sampling, transition finding and time-code queue.
module dets_stamper #(
    parameter int CNT_W       = 12,
    parameter int SYNC_STAGES = 2,
    parameter int FIFO_DEPTH  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_in,
    input  logic             ts_ready,
    output logic             ts_valid,
    output logic [CNT_W:0]   ts_data,
    output logic             ts_overflow
);
    localparam int TS_W = CNT_W + 1;
    localparam int SYNC = (SYNC_STAGES < dets_pkg::MIN_SYNC) ? dets_pkg::MIN_SYNC : SYNC_STAGES;

    logic            smp_rise, smp_fall;
    logic            ev_valid;
    logic [TS_W-1:0] ev_stamp;

    dets_sampler #(.STAGES(SYNC)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_async (hit_in),
        .smp_rise  (smp_rise),
        .smp_fall  (smp_fall)
    );

    dets_edge_find #(.CNT_W(CNT_W), .LAT(SYNC)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_rise (smp_rise),
        .smp_fall (smp_fall),
        .ev_valid (ev_valid),
        .ev_stamp (ev_stamp)
    );

    dets_fifo #(.W(TS_W), .DEPTH(FIFO_DEPTH)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (ev_valid),
        .wr_data  (ev_stamp),
        .rd_req   (ts_ready),
        .rd_valid (ts_valid),
        .rd_data  (ts_data),
        .ovf      (ts_overflow)
    );

    // R8
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_valid && !ts_ready) |=> (ts_valid && $stable(ts_data)));

endmodule

// File: tb/dets_stamper_test.sv
`timescale 1ns/1ps
module dets_stamper_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hit_in = 1'b0;
    logic        ts_ready = 1'b0;
    logic        ts_valid;
    logic [12:0] ts_data;
    logic        ts_overflow;

    int compared = 0;
    int mismatched = 0;
    int bidx = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) bidx <= 0;
        else        bidx <= bidx + 1;
    end

    dets_stamper uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_in      (hit_in),
        .ts_ready    (ts_ready),
        .ts_valid    (ts_valid),
        .ts_data     (ts_data),
        .ts_overflow (ts_overflow)
    );

    // Fields: [15] rise after falling edge, [14:8] periods high, [7:0] periods low
    localparam logic [15:0] VEC [8] = '{
        16'h0103, 16'h8103, 16'h0402, 16'h8902,
        16'h0205, 16'h8303, 16'h1402, 16'h8204
    };

    function automatic logic [12:0] mk(input int c, input bit h);
        logic [11:0] cc;
        cc = c[11:0];
        return {cc, h};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drives a rise after rising edge k; early = before the falling edge.
    task automatic launch(input bit late, output int coarse, output bit half);
        int k;
        @(posedge clk);
        #1;
        k = bidx - 1;
        if (!late) begin
            #1 hit_in = 1'b1;
            coarse = k;
            half = 1'b1;
        end else begin
            #6 hit_in = 1'b1;
            coarse = k + 1;
            half = 1'b0;
        end
    endtask

    task automatic pop();
        ts_ready = 1'b1;
        @(posedge clk);
        #1 ts_ready = 1'b0;
    endtask

    task automatic do_reset();
        @(posedge clk);
        #2 rst_n = 1'b0;
        hit_in = 1'b0;
        ts_ready = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int c, c2;
        bit h, h2;
        logic [12:0] exp_a [9];

        // Reset state (R1); first code after reset checks period 0 and latency (R5)
        #22 rst_n = 1'b1;
        #1;
        chk("R1 valid after reset", 32'(ts_valid), 32'd0);
        chk("R1 overflow after reset", 32'(ts_overflow), 32'd0);
        launch(1'b0, c, h);
        chk("R1 first period index", 32'(c), 32'd0);
        @(posedge clk); #1;
        chk("R5 not valid at k+1", 32'(ts_valid), 32'd0);
        @(posedge clk); #1;
        chk("R5 not valid at k+2", 32'(ts_valid), 32'd0);
        @(posedge clk); #1;
        chk("R5 valid at k+3", 32'(ts_valid), 32'd1);
        chk("R1 R3 code of first rise", 32'(ts_data), 32'(mk(0, 1'b1)));
        #1 hit_in = 1'b0;
        pop();
        chk("R8 empty after pop", 32'(ts_valid), 32'd0);
        repeat (2) @(posedge clk);

        // Vector table: R2, R3, R4, R6, R8
        for (int i = 0; i < 8; i++) begin
            launch(VEC[i][15], c, h);
            repeat (int'(VEC[i][14:8])) @(posedge clk);
            #2 hit_in = 1'b0;
            repeat (int'(VEC[i][7:0])) @(posedge clk);
            #1;
            chk(VEC[i][15] ? "R4 R2 valid" : "R3 R2 valid", 32'(ts_valid), 32'd1);
            chk(VEC[i][15] ? "R4 R2 code" : "R3 R2 code", 32'(ts_data), 32'(mk(c, h)));
            pop();
            chk("R6 R8 single code per pulse", 32'(ts_valid), 32'd0);
        end

        // Single-sample dropout must not retrigger (R7)
        launch(1'b0, c, h);
        repeat (3) @(posedge clk);
        #2 hit_in = 1'b0;
        #5 hit_in = 1'b1;
        repeat (3) @(posedge clk);
        #2 hit_in = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        chk("R7 glitch first code", 32'(ts_data), 32'(mk(c, h)));
        pop();
        chk("R7 glitch no second code", 32'(ts_valid), 32'd0);

        // Exactly one full low period re-arms (R7)
        launch(1'b0, c, h);
        repeat (3) @(posedge clk);
        #1 c2 = bidx;
        h2 = 1'b1;
        #1 hit_in = 1'b0;
        @(posedge clk);
        #2 hit_in = 1'b1;
        repeat (2) @(posedge clk);
        #2 hit_in = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        chk("R7 rearm first code", 32'(ts_data), 32'(mk(c, h)));
        pop();
        chk("R7 rearm second valid", 32'(ts_valid), 32'd1);
        chk("R7 rearm second code", 32'(ts_data), 32'(mk(c2, h2)));
        pop();
        chk("R7 rearm then empty", 32'(ts_valid), 32'd0);

        // Overfill: 9 codes, no reads (R8, R9)
        for (int i = 0; i < 9; i++) begin
            if (i == 8) begin
                chk("R9 no loss when exactly full", 32'(ts_overflow), 32'd0);
            end
            launch(1'b0, c, h);
            exp_a[i] = mk(c, h);
            @(posedge clk);
            #2 hit_in = 1'b0;
            repeat (3) @(posedge clk);
        end
        repeat (2) @(posedge clk);
        #1;
        chk("R9 loss flag raised", 32'(ts_overflow), 32'd1);
        for (int i = 0; i < 8; i++) begin
            chk("R8 drain valid", 32'(ts_valid), 32'd1);
            chk("R8 drain order", 32'(ts_data), 32'(exp_a[i]));
            pop();
        end
        chk("R9 ninth code dropped", 32'(ts_valid), 32'd0);
        chk("R9 loss flag sticky", 32'(ts_overflow), 32'd1);

        // Reset clears the flag, then coarse wrap (R1, R10)
        do_reset();
        #1;
        chk("R1 overflow cleared by reset", 32'(ts_overflow), 32'd0);
        do begin
            @(posedge clk);
            #1;
        end while (bidx - 1 != 4094);
        launch(1'b1, c, h);
        repeat (5) @(posedge clk);
        #2 hit_in = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R10 wrap to zero", 32'(ts_data), 32'(13'h0000));
        chk("R10 wrap value", 32'(ts_data), 32'(mk(c, h)));
        pop();
        launch(1'b0, c, h);
        repeat (2) @(posedge clk);
        #2 hit_in = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R10 after wrap", 32'(ts_data), 32'(mk(c, h)));
        chk("R10 after wrap small", 32'(c < 4096 ? 0 : 1), 32'd1);
        pop();
        chk("R8 empty at end", 32'(ts_valid), 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule